// File: doc/BRIEF.md
# Serial Port Word-Rate Generator

This block produces the timing for a synchronous serial audio port. From the processor clock it derives a serial base tick through a chain of divide-by-2 stages, plus one more halving that a mode bit can select. It then divides that tick by a programmable 16-bit period to form a one-cycle bit-clock enable. It counts bit enables to mark the end of each word, where a word is 8, 16, 24 or 32 bits long.

Software programs two registers through write strobes: a control word that carries the extra-halving bit and the word-length field, and the period register. A write to either register restarts every internal counter, so the new timing starts from a known phase. The block also reports, as a cycle count, how many processor cycles one word lasts under the current settings. A data shifter can use this figure to plan transfers.

Top module: `sp_word_rate`

## Requirements
- R1: After reset the control and period registers hold zero, `bit_en` and `word_stb` stay low, and `word_cycles` reads 0.
- R2: With control bit 2 clear and period P > 0, the base tick is one processor cycle in 4. `bit_en` pulses for one cycle every 4·P cycles. Its first pulse falls 4·P−1 cycles after the cycle in which the restarting write was clocked in.
- R3: With control bit 2 set, the divisor doubles: `bit_en` pulses every 8·P cycles, and the first pulse comes 8·P−1 cycles after the restart.
- R4: Control bits [19:18] hold a value L. The word is 8·(L+1) bits long. `word_stb` is high only in a cycle where `bit_en` is high, and it marks every 8·(L+1)-th bit enable counted from the restart.
- R5: `word_cycles` equals D·P·8·(L+1), where D is 4 or 8 as set by control bit 2.
- R6: A period value of 0 stops the bit clock. No `bit_en`, no `word_stb`, and `word_cycles` reads 0.
- R7: A write to the control register or to the period register clears the prescaler, the bit divider and the bit counter on the same clock edge. Timing then restarts from zero, whatever phase the counters held before.
- R8: Control bits other than bit 2 and bits [19:18] have no effect on the timing or on `word_cycles`.
- R9: The smallest period, P = 1, gives one bit enable per base tick, which is every D cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control register (also restarts counters) |
| ctl_data | input | CTL_W (32) | Control word; bit 2 selects the extra halving, bits [19:18] select the word length |
| per_wr | input | 1 | Write strobe for the period register (also restarts counters) |
| per_data | input | PER_W (16) | Bit-clock divisor in base ticks |
| bit_en | output | 1 | One-cycle bit-clock enable |
| word_stb | output | 1 | One-cycle strobe on the last bit enable of each word |
| word_cycles | output | CW (24) | Processor cycles per word under the current settings |

## Verification
The bench builds the block with its default parameters: a 16-bit period, two fixed halving stages and a 2-bit length field. These settings reach all four word lengths, both base divisors, and the full-scale period for the word-cycle figure. Small periods (1 to 5) keep whole 32-bit words within a few hundred cycles. This lets the bench measure the exact cycle of the first bit enable, the gap between bit enables and the position of the first word strobe for every combination it drives. A restart issued in the middle of a count then shows whether the phase truly returns to zero.

// File: rtl/sp_rate_pkg.sv
`timescale 1ns/1ps
package sp_rate_pkg;

  // Number of bits in one word for a length code.
  function automatic int unsigned word_bits(input int unsigned len_code);
    return 8 * (len_code + 1);
  endfunction

  // Processor cycles per base tick.
  function automatic int unsigned base_div(input int unsigned fixed_stages,
                                           input bit extra_half);
    return 32'd1 << (fixed_stages + (extra_half ? 1 : 0));
  endfunction

  // Processor cycles per bit enable.
  function automatic longint unsigned bit_period(input int unsigned per,
                                                 input int unsigned fixed_stages,
                                                 input bit extra_half);
    return longint'(base_div(fixed_stages, extra_half)) * longint'(per);
  endfunction

  // Processor cycles per word.
  function automatic longint unsigned word_period(input int unsigned per,
                                                  input int unsigned fixed_stages,
                                                  input bit extra_half,
                                                  input int unsigned len_code);
    return bit_period(per, fixed_stages, extra_half) * longint'(word_bits(len_code));
  endfunction

endpackage

// File: rtl/sp_prescaler.sv
`timescale 1ns/1ps
module sp_prescaler #(
  parameter int FIXED_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic extra_half,
  output logic base_tick
);
  localparam int NST = FIXED_STAGES + 1;

  logic [NST-1:0] tgl;
  logic [NST:0]   carry;

  assign carry[0] = 1'b1;

  for (genvar s = 0; s < NST; s++) begin : g_stage
    assign carry[s+1] = carry[s] & tgl[s];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          tgl[s] <= 1'b0;
      else if (restart)    tgl[s] <= 1'b0;
      else if (carry[s])   tgl[s] <= ~tgl[s];
    end
  end

  assign base_tick = extra_half ? carry[NST] : carry[FIXED_STAGES];
endmodule

// File: rtl/sp_bit_divider.sv
`timescale 1ns/1ps
module sp_bit_divider #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             base_tick,
  input  logic [PER_W-1:0] period,
  output logic             bit_en
);
  logic [PER_W-1:0] cnt;
  logic             per_zero;
  logic             at_last;

  assign per_zero = (period == '0);
  assign at_last  = (cnt == period - PER_W'(1));
  assign bit_en   = base_tick & ~per_zero & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart)                 cnt <= '0;
    else if (base_tick && !per_zero)  cnt <= at_last ? '0 : cnt + PER_W'(1);
  end
endmodule

// File: rtl/sp_word_counter.sv
`timescale 1ns/1ps
module sp_word_counter #(
  parameter int LEN_W = 2,
  localparam int BW = LEN_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             bit_en,
  input  logic [LEN_W-1:0] len_code,
  output logic             word_stb,
  output logic [BW-1:0]    bit_idx
);
  logic [BW-1:0] last_idx;

  assign last_idx = BW'(sp_rate_pkg::word_bits(32'(len_code)) - 1);
  assign word_stb = bit_en & (bit_idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bit_idx <= '0;
    else if (restart)  bit_idx <= '0;
    else if (bit_en)   bit_idx <= word_stb ? '0 : bit_idx + BW'(1);
  end
endmodule

// File: rtl/sp_word_rate.sv
`timescale 1ns/1ps
module sp_word_rate #(
  parameter int CTL_W        = 32,
  parameter int PER_W        = 16,
  parameter int FIXED_STAGES = 2,
  parameter int LEN_W        = 2,
  parameter int XHALF_POS    = 2,
  parameter int LEN_POS      = 18,
  localparam int BW = LEN_W + 3,
  localparam int CW = PER_W + FIXED_STAGES + 1 + BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_data,
  output logic             bit_en,
  output logic             word_stb,
  output logic [CW-1:0]    word_cycles
);
  logic             xhalf_q;
  logic [LEN_W-1:0] len_q;
  logic [PER_W-1:0] per_q;

  // Named internal events for the checker.
  logic             restart;
  logic             base_tick;
  logic [BW-1:0]    bit_idx;
  logic [CW-1:0]    bit_cycles_w;
  logic [BW-1:0]    word_bits_w;

  assign restart = ctl_wr | per_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xhalf_q <= 1'b0;
      len_q   <= '0;
    end else if (ctl_wr) begin
      xhalf_q <= ctl_data[XHALF_POS];
      len_q   <= ctl_data[LEN_POS +: LEN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       per_q <= '0;
    else if (per_wr)  per_q <= per_data;
  end

  sp_prescaler #(.FIXED_STAGES(FIXED_STAGES)) i_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .extra_half(xhalf_q), .base_tick(base_tick)
  );

  sp_bit_divider #(.PER_W(PER_W)) i_div (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .base_tick(base_tick), .period(per_q), .bit_en(bit_en)
  );

  sp_word_counter #(.LEN_W(LEN_W)) i_wcnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .bit_en(bit_en),
    .len_code(len_q), .word_stb(word_stb), .bit_idx(bit_idx)
  );

  assign word_bits_w  = BW'(sp_rate_pkg::word_bits(32'(len_q)));
  assign bit_cycles_w = CW'(sp_rate_pkg::bit_period(32'(per_q), FIXED_STAGES, xhalf_q));
  assign word_cycles  = CW'(sp_rate_pkg::word_period(32'(per_q), FIXED_STAGES,
                                                     xhalf_q, 32'(len_q)));
endmodule

// File: rtl/sp_word_rate_chk.sv
`timescale 1ns/1ps
module sp_word_rate_chk #(
  parameter int BW = 5,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          bit_en,
  input logic          word_stb,
  input logic [CW-1:0] bit_cycles_w,
  input logic [CW-1:0] word_cycles,
  input logic [BW-1:0] word_bits_w
);
  logic [CW-1:0] bit_gap;
  logic [CW-1:0] word_gap;
  logic [BW-1:0] bits_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_gap   <= '0;
      word_gap  <= '0;
      bits_seen <= '0;
    end else if (restart) begin
      bit_gap   <= '0;
      word_gap  <= '0;
      bits_seen <= '0;
    end else begin
      bit_gap   <= bit_en   ? '0 : bit_gap + CW'(1);
      word_gap  <= word_stb ? '0 : word_gap + CW'(1);
      bits_seen <= word_stb ? '0 : (bit_en ? bits_seen + BW'(1) : bits_seen);
    end
  end

  // R2 / R3 / R9: spacing of bit enables
  a_r2_bit_gap: assert property (@(posedge clk) disable iff (!rst_n || restart)
    bit_en |-> (bit_gap == bit_cycles_w - CW'(1)));

  // R5: spacing of word strobes matches the reported word period
  a_r5_word_gap: assert property (@(posedge clk) disable iff (!rst_n || restart)
    word_stb |-> (word_gap == word_cycles - CW'(1)));

  // R4: bit enables counted per word
  a_r4_bits_per_word: assert property (@(posedge clk) disable iff (!rst_n || restart)
    word_stb |-> (bits_seen == word_bits_w - BW'(1)));

  // R4: strobe only together with a bit enable
  a_r4_word_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> bit_en);

  // R6: stopped clock when the word period is zero
  a_r6_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cycles == '0) |-> (!bit_en && !word_stb));

  // R7: the cycle after a restart is always quiet
  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !bit_en);
endmodule

bind sp_word_rate sp_word_rate_chk #(.BW(BW), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .bit_en(bit_en),
  .word_stb(word_stb), .bit_cycles_w(bit_cycles_w),
  .word_cycles(word_cycles), .word_bits_w(word_bits_w)
);

// File: tb/test_sp_word_rate.sv
`timescale 1ns/1ps
module test_sp_word_rate;
  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [31:0]   ctl_data = '0;
  logic          per_wr = 1'b0;
  logic [15:0]   per_data = '0;
  logic          bit_en;
  logic          word_stb;
  logic [CW-1:0] word_cycles;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sp_word_rate i_sp_word_rate (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .per_wr(per_wr), .per_data(per_data), .bit_en(bit_en),
    .word_stb(word_stb), .word_cycles(word_cycles)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Leaves the bench at the falling edge of cycle 0 after the write.
  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_data = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_per(input logic [15:0] v);
    @(negedge clk); per_wr = 1'b1; per_data = v;
    @(negedge clk); per_wr = 1'b0;
  endtask

  // Measures from cycle 0 onward; expectations from D, P, W.
  task automatic measure(input string req, input int d, input int p, input int w);
    int first_bit = -1, second_bit = -1, first_word = -1, bits_before = 0;
    int any = 0;
    int lim = (p == 0) ? 300 : w * d * p + 2 * d * p + 4;
    for (int i = 0; i < lim; i++) begin
      if (bit_en) begin
        any++;
        if (first_bit < 0) first_bit = i;
        else if (second_bit < 0) second_bit = i;
        if (first_word < 0 && !word_stb) bits_before++;
      end
      if (word_stb && first_word < 0) first_word = i;
      @(negedge clk);
    end
    if (p == 0) begin
      chk(any == 0 && first_word < 0, req, any, 0);
    end else begin
      chk(first_bit == d * p - 1, req, first_bit, d * p - 1);
      chk(second_bit - first_bit == d * p, req, second_bit - first_bit, d * p);
      chk(first_word == w * d * p - 1, req, first_word, w * d * p - 1);
      chk(bits_before == w - 1, req, bits_before, w - 1);
    end
    chk(word_cycles == CW'(d * p * w), req, word_cycles, d * p * w);
  endtask

  task automatic t_reset();  // R1
    chk(!bit_en && !word_stb, "R1", {bit_en, word_stb}, 0);
    chk(word_cycles == '0, "R1", word_cycles, 0);
    measure("R1", 4, 0, 8);
  endtask

  task automatic t_base();   // R2 R4 R5
    wr_ctl(32'h0);
    wr_per(16'd5);
    measure("R2", 4, 5, 8);
  endtask

  task automatic t_xhalf();  // R3 R4
    wr_per(16'd3);
    wr_ctl(32'h0004_0004);
    measure("R3", 8, 3, 16);
  endtask

  task automatic t_len32();  // R4
    wr_per(16'd2);
    wr_ctl(32'h000C_0000);
    measure("R4", 4, 2, 32);
  endtask

  task automatic t_min();    // R9
    wr_per(16'd1);
    wr_ctl(32'h0008_0004);
    measure("R9", 8, 1, 24);
  endtask

  task automatic t_zero();   // R6
    wr_ctl(32'h0004_0000);
    wr_per(16'd0);
    measure("R6", 4, 0, 16);
  endtask

  task automatic t_restart(); // R7
    wr_ctl(32'h0);
    wr_per(16'd5);
    repeat (7) @(negedge clk);
    wr_ctl(32'h0);
    measure("R7", 4, 5, 8);
    wr_ctl(32'h0004_0000);
    repeat (33) @(negedge clk);
    wr_per(16'd4);
    measure("R7", 4, 4, 16);
  endtask

  task automatic t_junk();   // R8
    wr_per(16'd3);
    wr_ctl(32'hFFF3_FFFB);
    measure("R8", 4, 3, 8);
  endtask

  task automatic t_fullscale(); // R5
    wr_ctl(32'h000C_0004);
    wr_per(16'hFFFF);
    chk(word_cycles == CW'(8 * 65535 * 32), "R5", word_cycles, 8 * 65535 * 32);
    wr_ctl(32'h0);
    chk(word_cycles == CW'(4 * 65535 * 8), "R5", word_cycles, 4 * 65535 * 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_xhalf();
    t_len32();
    t_min();
    t_zero();
    t_restart();
    t_junk();
    t_fullscale();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule